// File: doc/BRIEF.md
# Parallel-Port Enhanced-Mode Slave with 16-bit Word Registers

This block sits on the peripheral side of a PC-style parallel port. It stays passive until the host runs the IEEE 1284 negotiation for the enhanced (EPP) mode. After that, it serves byte-wide address and data cycles. An address cycle selects one of a small set of 16-bit internal registers. Data cycles move each register as a pair of bytes, with the high byte first.

All host lines enter through two-flop synchronizers, and strobe edges are found on the synchronized copies. The block raises a wait/acknowledge output for each strobe it accepts. It drives the byte bus only while a read strobe is being served. The bus is split into an input, an output and an output enable, which the pad ring combines into a tristate pin.

A word that is half transferred is abandoned in two cases: when a new address is written, or when the second byte does not arrive within a programmable number of clock cycles. In either case the next data byte is taken as a high byte.

Top module: `epp_word_slave`

## Requirements
- R1: After reset, wait_o, data_oe_o and epp_mode_o are low. The address latch is 0x00 and every register reads 0x0000.
- R2: epp_mode_o goes high after the following host sequence on the synchronized lines: nselect_i high, nautofd_i low, nstrobe_i high and data_i equal to 0x40; then nstrobe_i low; then nautofd_i and nstrobe_i both high. It stays high until reset.
- R3: Before epp_mode_o is high, strobes are ignored: wait_o stays low, and neither the address nor any register changes.
- R4: nselect_i low with nstrobe_i low (address write) latches data_i as the address. nselect_i low with nstrobe_i high (address read) drives the latched address on data_o.
- R5: nautofd_i low with nstrobe_i low is a data write. The first byte is taken as bits 15:8 and the second as bits 7:0, and the word is stored when the second byte arrives. Bytes 0x12 then 0x34 store 0x1234.
- R6: nautofd_i low with nstrobe_i high is a data read. The first read returns bits 15:8 of the selected register and the second returns bits 7:0.
- R7: An address write resets the byte phase. A word with only one byte written is discarded, and its register keeps its old value. A read that is cut short restarts at the high byte of the new address.
- R8: When TIMEOUT_CYC clock cycles pass after a first byte with no second byte, the byte phase returns to the high byte. This applies to both writes and reads.
- R9: Addresses at or above NUM_REGS select no register. Writes to them are dropped and reads from them return 0x00 bytes.
- R10: wait_o rises for each accepted strobe and falls after the strobe is released. data_oe_o is high only for read strobes, and data_o holds steady while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nstrobe_i | input | 1 | Host write line, low = write cycle |
| nselect_i | input | 1 | Host address strobe, active low |
| nautofd_i | input | 1 | Host data strobe, active low |
| data_i | input | 8 | Byte bus from host |
| data_o | output | 8 | Byte bus to host |
| data_oe_o | output | 1 | Output enable for the byte bus |
| wait_o | output | 1 | Strobe acknowledge (busy / wait) |
| epp_mode_o | output | 1 | Negotiation complete |

## Verification
The bench targets the discard paths:
- A partial write followed by an address change. A design that stores the lone byte would corrupt the old word.
- A partial read followed by an address change. A design that keeps the phase would return the low byte of the new register first.
- An idle gap longer than the timeout after a single byte. A design without the timer would pair bytes from unrelated accesses.

The bench also checks three more cases:
- Strobes before negotiation, which must not take effect.
- Out-of-range addresses, which must alias to no register.
- A read strobe compared with a write strobe, to confirm that only the read enables the bus.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    NEG_WAIT  = 2'd0,
    NEG_REQ   = 2'd1,
    NEG_STB   = 2'd2,
    NEG_DONE  = 2'd3
  } neg_state_e;

  localparam logic [7:0] NEG_CODE = 8'h40;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/epp_negotiate.sv
module epp_negotiate
  import epp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nstb_i,
  input  logic       nsel_i,
  input  logic       nafd_i,
  input  logic [7:0] data_i,
  output logic       mode_o
);
  neg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      NEG_WAIT: if (data_i == NEG_CODE && nsel_i && !nafd_i && nstb_i) st_d = NEG_REQ;
      NEG_REQ: begin
        if (nafd_i)       st_d = NEG_WAIT;
        else if (!nstb_i) st_d = NEG_STB;
      end
      NEG_STB:  if (nstb_i && nafd_i) st_d = NEG_DONE;
      NEG_DONE: st_d = NEG_DONE;
      default:  st_d = NEG_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= NEG_WAIT;
    else         st_q <= st_d;
  end

  assign mode_o = (st_q == NEG_DONE);
endmodule

// File: rtl/epp_regfile.sv
module epp_regfile #(
  parameter int NUM_REGS = 16,
  parameter int WORD_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))      mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/epp_word_slave.sv
module epp_word_slave #(
  parameter int NUM_REGS    = 16,
  parameter int TIMEOUT_CYC = 1200,
  localparam int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TMR_W      = $clog2(TIMEOUT_CYC + 1),
  localparam int WORD_W     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nstrobe_i,
  input  logic       nselect_i,
  input  logic       nautofd_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       wait_o,
  output logic       epp_mode_o
);
  localparam int SYNC_W = 11;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [8:0] ADDR_LIMIT = 9'(NUM_REGS);

  logic [SYNC_W-1:0] sync_q;
  logic nstb_s, nsel_s, nafd_s;
  logic [7:0] data_s;

  epp_sync #(.W(SYNC_W), .RST_VAL({3'b111, 8'h00})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nstrobe_i, nselect_i, nautofd_i, data_i}),
    .q_o   (sync_q)
  );
  assign {nstb_s, nsel_s, nafd_s, data_s} = sync_q;

  logic mode;
  epp_negotiate u_neg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nstb_i(nstb_s),
    .nsel_i(nsel_s),
    .nafd_i(nafd_s),
    .data_i(data_s),
    .mode_o(mode)
  );

  logic act, act_q, start, is_addr, is_wr;
  logic [7:0] addr_q, hold_q, rd_q;
  logic odd_q, wait_q, oe_q, in_rng;
  logic [TMR_W-1:0] tmr_q;
  logic we;
  logic [WORD_W-1:0] rdata, rd_word;

  assign act     = mode && (!nsel_s || !nafd_s);
  assign start   = act && !act_q;
  assign is_addr = !nsel_s;
  assign is_wr   = !nstb_s;
  assign in_rng  = {1'b0, addr_q} < ADDR_LIMIT;
  assign we      = start && !is_addr && is_wr && odd_q && in_rng;
  assign rd_word = in_rng ? rdata : '0;

  epp_regfile #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .idx_i  (addr_q[IDX_W-1:0]),
    .wdata_i({hold_q, data_s}),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wait_q <= 1'b0;
      oe_q   <= 1'b0;
      addr_q <= '0;
      hold_q <= '0;
      rd_q   <= '0;
      odd_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      act_q <= act;
      if (!act) begin
        wait_q <= 1'b0;
        oe_q   <= 1'b0;
      end
      if (start) begin
        wait_q <= 1'b1;
        if (is_addr) begin
          if (is_wr) begin
            addr_q <= data_s;
            odd_q  <= 1'b0;
          end else begin
            oe_q <= 1'b1;
            rd_q <= addr_q;
          end
        end else begin
          tmr_q <= TMR_LOAD;
          odd_q <= !odd_q;
          if (is_wr) begin
            if (!odd_q) hold_q <= data_s;
          end else begin
            oe_q <= 1'b1;
            rd_q <= odd_q ? rd_word[7:0] : rd_word[15:8];
          end
        end
      end else if (odd_q) begin
        // idle watchdog on a half-moved word
        if (tmr_q == '0) odd_q <= 1'b0;
        else             tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign data_o     = rd_q;
  assign data_oe_o  = oe_q;
  assign wait_o     = wait_q;
  assign epp_mode_o = mode;
endmodule

// File: rtl/epp_word_slave_chk.sv
module epp_word_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       wait_o,
  input logic       epp_mode_o
);
  a_r2_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epp_mode_o |=> epp_mode_o);

  a_r3_quiet_before_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_mode_o |-> (!wait_o && !data_oe_o));

  a_r10_oe_inside_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> wait_o);

  a_r10_oe_with_wait_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $rose(wait_o));

  a_r10_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
endmodule

bind epp_word_slave epp_word_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .wait_o    (wait_o),
  .epp_mode_o(epp_mode_o)
);

// File: tb/epp_word_slave_bench.sv
`timescale 1ns/1ps
module epp_word_slave_bench;
  localparam int NREG = 16;
  localparam int TOUT = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nstb = 1'b0, nsel = 1'b0, nafd = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic oe, wt, mode;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] model [NREG];

  always #5 clk = ~clk;

  epp_word_slave #(.NUM_REGS(NREG), .TIMEOUT_CYC(TOUT)) u_epp_word_slave (
    .clk_i(clk), .rst_ni(rst_n), .nstrobe_i(nstb), .nselect_i(nsel),
    .nautofd_i(nafd), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .wait_o(wt), .epp_mode_o(mode)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one host cycle; samples bus, enable and wait mid-strobe
  task automatic bus(input bit is_addr, input bit wr, input logic [7:0] d,
                     output logic [7:0] got, output logic oe_s, output logic wt_s);
    @(negedge clk);
    nstb = !wr;
    din  = d;
    cyc(2);
    if (is_addr) nsel = 1'b0; else nafd = 1'b0;
    cyc(6);
    got = dout; oe_s = oe; wt_s = wt;
    nsel = 1'b1; nafd = 1'b1;
    cyc(2);
    nstb = 1'b1;
    cyc(5);
  endtask

  logic [7:0] g; logic go, gw;

  task automatic set_addr(input logic [7:0] a);
    bus(1, 1, a, g, go, gw);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    bus(0, 1, b, g, go, gw);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    bus(0, 0, 8'h00, b, go, gw);
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] w);
    set_addr(a);
    wr_byte(w[15:8]);
    wr_byte(w[7:0]);
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    logic [7:0] h, l;
    set_addr(a);
    rd_byte(h);
    rd_byte(l);
    w = {h, l};
  endtask

  function automatic logic [15:0] expect_word(input logic [7:0] a);
    return (a < NREG) ? model[a[3:0]] : 16'h0000;
  endfunction

  task automatic negotiate();
    @(negedge clk);
    din = 8'h40; nstb = 1'b1; nsel = 1'b0; nafd = 1'b1; cyc(8);
    nsel = 1'b1; nafd = 1'b0; cyc(8);
    nstb = 1'b0; cyc(8);
    nafd = 1'b1; nstb = 1'b1; cyc(8);
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0] b, a;
    void'($urandom(32'd1284));
    for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
    cyc(3);
    // R1 reset state
    check("R1 wait", {15'd0, wt}, 16'd0);
    check("R1 oe", {15'd0, oe}, 16'd0);
    check("R1 mode", {15'd0, mode}, 16'd0);
    rst_n = 1'b1;
    cyc(3);
    // R3 strobes before negotiation ignored
    bus(1, 1, 8'h03, g, go, gw);
    check("R3 no wait on addr", {15'd0, gw}, 16'd0);
    bus(0, 1, 8'hAB, g, go, gw);
    check("R3 no wait on data", {15'd0, gw}, 16'd0);
    bus(0, 1, 8'hCD, g, go, gw);
    check("R3 mode still low", {15'd0, mode}, 16'd0);
    // R2 negotiation
    negotiate();
    check("R2 mode high", {15'd0, mode}, 16'd1);
    // R1/R3 address latch still 0
    bus(1, 0, 8'h00, g, go, gw);
    check("R1 R3 addr readback zero", {8'd0, g}, 16'h0000);
    read_word(8'h03, w);
    check("R3 reg3 untouched", w, 16'h0000);
    // R5 basic write and R4 readback
    write_word(8'h05, 16'h1234); model[5] = 16'h1234;
    bus(1, 0, 8'h00, g, go, gw);
    check("R4 addr read", {8'd0, g}, 16'h0005);
    check("R10 read drives bus", {15'd0, go}, 16'd1);
    // R10 write strobe acknowledged, bus not driven
    bus(0, 1, 8'h00, g, go, gw);
    check("R10 wait on write", {15'd0, gw}, 16'd1);
    check("R10 no oe on write", {15'd0, go}, 16'd0);
    bus(0, 1, 8'h00, g, go, gw);
    model[5] = 16'h0000;
    check("R10 wait released", {15'd0, wt}, 16'd0);
    write_word(8'h05, 16'h1234); model[5] = 16'h1234;
    // R6 byte order
    set_addr(8'h05);
    rd_byte(b); check("R6 high first", {8'd0, b}, 16'h0012);
    rd_byte(b); check("R6 low second", {8'd0, b}, 16'h0034);
    // R7 partial write discarded by address change
    write_word(8'h06, 16'h4321); model[6] = 16'h4321;
    set_addr(8'h06); wr_byte(8'h99);
    set_addr(8'h07); wr_byte(8'h11); wr_byte(8'h22); model[7] = 16'h1122;
    read_word(8'h06, w); check("R7 old word kept", w, 16'h4321);
    read_word(8'h07, w); check("R7 fresh word", w, 16'h1122);
    // R7 read cut short by address write
    set_addr(8'h06); rd_byte(b);
    read_word(8'h07, w); check("R7 read restarts", w, 16'h1122);
    // R8 write timeout
    set_addr(8'h08); wr_byte(8'hEE);
    cyc(TOUT + 20);
    wr_byte(8'h56); wr_byte(8'h78); model[8] = 16'h5678;
    read_word(8'h08, w); check("R8 write timeout", w, 16'h5678);
    // R8 read timeout
    set_addr(8'h07); rd_byte(b);
    cyc(TOUT + 20);
    rd_byte(b); check("R8 read timeout high again", {8'd0, b}, 16'h0011);
    rd_byte(b); check("R8 read timeout low", {8'd0, b}, 16'h0022);
    // R9 out of range
    write_word(8'h90, 16'hBEEF);
    read_word(8'h90, w); check("R9 oor read zero", w, 16'h0000);
    read_word(8'h00, w); check("R9 alias untouched", w, 16'h0000);
    // random traffic, R4 R5 R6 R9
    for (int i = 0; i < 40; i++) begin
      a = 8'($urandom_range(0, NREG + 3));
      if ($urandom_range(0, 1) == 0) begin
        w = 16'($urandom);
        write_word(a, w);
        if (a < NREG) model[a[3:0]] = w;
      end else begin
        read_word(a, w);
        check("R5 R6 R9 random read", w, expect_word(a));
        bus(1, 0, 8'h00, g, go, gw);
        check("R4 random addr read", {8'd0, g}, {8'd0, a});
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule